// File: doc/BRIEF.md
# Two-Bit Gray Up/Down Counter

This block is a small synchronous counter that walks a four-state cycle in which neighbouring codes differ in a single bit. On every rising clock edge it moves one position forward or one position back along that cycle, as chosen by a direction input. Because only one bit ever toggles per step, the code can be sampled by logic in another timing domain, or decoded into positions, without transient wrong values from two bits moving at once.

The output is the state register itself, in Moore style: nothing is decoded after the flops, so the output moves only just after a rising edge and never follows the direction input between edges. A synchronous active-low reset forces the code to 00 from any state and overrides the direction input.

Top module: `gray_updown_counter`

## Requirements
- R1: When `rst_n` is 0 at a rising edge of `clk`, `gray_out` is 2'b00 after that edge, whatever its previous value.
- R2: Reset takes priority over direction: with `rst_n` at 0, `gray_out` becomes 2'b00 after the edge for either value of `count_up`.
- R3: With `rst_n` at 1 and `count_up` at 1, each rising edge advances `gray_out` along 00 -> 01 -> 11 -> 10 -> 00.
- R4: With `rst_n` at 1 and `count_up` at 0, each rising edge moves `gray_out` along 00 -> 10 -> 11 -> 01 -> 00.
- R5: On every rising edge with `rst_n` at 1, exactly one bit of `gray_out` changes.
- R6: `gray_out` changes only at a rising edge of `clk`; a change of `count_up` between edges leaves `gray_out` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low; forces code 00 |
| count_up | input | 1 | Direction: 1 steps forward, 0 steps backward |
| gray_out | output | 2 | Current code, taken straight from the state flops |

## Verification
Since the output is the state register, any wrong internal state is visible at `gray_out` in the very cycle after the faulty edge, either as a code off the expected position or as a step that toggles zero or two bits. The bench therefore compares every cycle against an independent model, covering both directions from all four codes and reset taken from each code with either direction. A separate check flips the direction mid-cycle to show the output holds until the next edge.

// File: rtl/gray_cnt_pkg.sv
// Package: shared codes and widths for the two-bit Gray counter.
// Assumes a four-position cycle; neighbours differ in one bit.
package gray_cnt_pkg;

    localparam int CODE_W = 2;

    typedef logic [CODE_W-1:0] code_t;

    // Positions of the cycle in forward order.
    localparam code_t POS_A = 2'b00;
    localparam code_t POS_B = 2'b01;
    localparam code_t POS_C = 2'b11;
    localparam code_t POS_D = 2'b10;

    localparam code_t RESET_CODE = POS_A;

endpackage

// File: rtl/gray_step_logic.sv
// Module: gray_step_logic
// Purely combinational next-code logic. Given the present code and a
// direction, returns the neighbour one position forward or back.
// Assumes the present code is always one of the four cycle positions.
module gray_step_logic
    import gray_cnt_pkg::*;
(
    input  code_t cur_code,
    input  logic  fwd,
    output code_t nxt_code
);

    // Select the neighbour in the requested direction.
    always_comb begin
        nxt_code = RESET_CODE;
        unique case (cur_code)
            POS_A: nxt_code = fwd ? POS_B : POS_D;
            POS_B: nxt_code = fwd ? POS_C : POS_A;
            POS_C: nxt_code = fwd ? POS_D : POS_B;
            POS_D: nxt_code = fwd ? POS_A : POS_C;
            default: nxt_code = RESET_CODE;
        endcase
    end

endmodule

// File: rtl/gray_state_reg.sv
// Module: gray_state_reg
// Holds the current code in D flops clocked on the rising edge.
// Synchronous active-low reset loads the reset code and overrides
// the next-code input.
module gray_state_reg
    import gray_cnt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  code_t d_code,
    output code_t q_code
);

    // Capture the next code, or the reset code while reset is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_code <= RESET_CODE;
        end else begin
            q_code <= d_code;
        end
    end

endmodule

// File: rtl/gray_updown_counter.sv
// Module: gray_updown_counter (top)
// Two-bit Gray up/down counter, Moore style: the output is the state
// register with no decoding after it. count_up=1 steps forward,
// count_up=0 steps back. Reset is synchronous and active low.
module gray_updown_counter
    import gray_cnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_up,
    output logic [CODE_W-1:0] gray_out
);

    code_t state_q;
    code_t state_d;

    gray_step_logic u_step (
        .cur_code (state_q),
        .fwd      (count_up),
        .nxt_code (state_d)
    );

    gray_state_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_code (state_d),
        .q_code (state_q)
    );

    // Drive the output straight from the flops.
    assign gray_out = state_q;

    // Records that a reset edge has been seen, so checks avoid X history.
    logic seen_rst;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_rst <= 1'b1;
        end else if (seen_rst !== 1'b1) begin
            seen_rst <= 1'b0;
        end
    end

    // R1 / R2: a reset edge yields code 00 whatever the direction.
    a_r1_reset_to_zero: assert property (@(posedge clk)
        !rst_n |=> gray_out == RESET_CODE);

    // R3: forward wrap from the last position returns to 00.
    a_r3_fwd_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst === 1'b1 && count_up && gray_out == POS_D) |=> gray_out == POS_A);

    // R4: backward step from 00 goes to 10.
    a_r4_back_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst === 1'b1 && !count_up && gray_out == POS_A) |=> gray_out == POS_D);

    // R5: each counting edge toggles exactly one output bit.
    a_r5_one_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst === 1'b1) |=> $countones(gray_out ^ $past(gray_out)) == 1);

endmodule

// File: tb/gray_updown_counter_bench.sv
module gray_updown_counter_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       count_up = 1'b0;
    logic [1:0] gray_out;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [1:0] exp_code;
        logic [1:0] prev_code;
        bit         was_reset;
        string      tag;
    } item_t;

    item_t sb_q[$];
    logic [1:0] mdl = 2'b00;

    always #10 clk = ~clk;  // 50 MHz

    gray_updown_counter u_gray_updown_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_up (count_up),
        .gray_out (gray_out)
    );

    // Bench model of the forward cycle 00,01,11,10.
    function automatic logic [1:0] fwd_of(input logic [1:0] c);
        case (c)
            2'b00: return 2'b01;
            2'b01: return 2'b11;
            2'b11: return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [1:0] back_of(input logic [1:0] c);
        case (c)
            2'b00: return 2'b10;
            2'b10: return 2'b11;
            2'b11: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    // Driver: set inputs at the falling edge, push the expected result.
    task automatic step(input logic r, input logic up);
        item_t it;
        @(negedge clk);
        rst_n    = r;
        count_up = up;
        it.prev_code = mdl;
        it.was_reset = !r;
        if (!r) begin
            mdl    = 2'b00;
            it.tag = up ? "R2" : "R1";
        end else if (up) begin
            mdl    = fwd_of(mdl);
            it.tag = "R3";
        end else begin
            mdl    = back_of(mdl);
            it.tag = "R4";
        end
        it.exp_code = mdl;
        sb_q.push_back(it);
    endtask

    // Monitor: pop and compare a quarter period after each rising edge.
    always @(posedge clk) begin
        #5;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (gray_out !== it.exp_code) begin
                failures++;
                $display("FAIL %s: gray_out=%b expected=%b", it.tag, gray_out, it.exp_code);
            end
            if (!it.was_reset) begin
                checks++;
                if ($countones(gray_out ^ it.prev_code) != 1) begin
                    failures++;
                    $display("FAIL R5: gray_out=%b prev=%b expected one-bit change",
                             gray_out, it.prev_code);
                end
            end
        end
    end

    // R6: flip direction mid-cycle; output must hold until next edge.
    task automatic hold_check();
        logic [1:0] seen;
        @(posedge clk);
        #2;
        seen = gray_out;
        count_up = ~count_up;
        #6;
        checks++;
        if (gray_out !== seen) begin
            failures++;
            $display("FAIL R6: gray_out=%b expected=%b", gray_out, seen);
        end
        count_up = ~count_up;
    endtask

    // Move the model and the design to a given code from 00 going forward.
    task automatic go_to(input logic [1:0] target);
        step(1'b0, 1'b0);
        while (mdl != target) step(1'b1, 1'b1);
    endtask

    initial begin : watchdog
        #(20 * 5000);
        failures++;
        $display("FAIL watchdog: run did not finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        logic [1:0] codes [4];
        codes[0] = 2'b00; codes[1] = 2'b01; codes[2] = 2'b11; codes[3] = 2'b10;
        // R1: reset from power-up
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        // R3: full forward lap
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1);
        // R4: full backward lap
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        // Reversal at every code, both ways (R3, R4)
        for (int k = 0; k < 4; k++) begin
            go_to(codes[k]);
            step(1'b1, 1'b0);
            step(1'b1, 1'b1);
            step(1'b1, 1'b1);
            step(1'b1, 1'b0);
        end
        // R1 / R2: reset taken from each code with either direction
        for (int k = 0; k < 4; k++) begin
            for (int d = 0; d < 2; d++) begin
                go_to(codes[k]);
                step(1'b0, d[0]);
            end
        end
        // R6: mid-cycle direction changes
        step(1'b1, 1'b1);
        hold_check();
        step(1'b1, 1'b0);
        hold_check();
        // Mixed pattern
        step(1'b1, 1'b1); step(1'b1, 1'b0); step(1'b1, 1'b0);
        step(1'b1, 1'b0); step(1'b1, 1'b1); step(1'b0, 1'b1);
        step(1'b1, 1'b0);
        repeat (3) @(posedge clk);
        #10;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule